// File: doc/BRIEF.md
# Nonvolatile Settings Commit Controller

This block decides when the three setting bytes of a dual audio attenuator (the wiper of channel 0, the wiper of channel 1 and the configuration byte) are saved to a slow nonvolatile store, and it restores them when the chip powers up. It watches the bus interface for the STOP that closes a write transaction. When the register interface reports that a setting changed and the registers are in nonvolatile mode, the controller captures all three bytes. It may then wait for a pending zero-crossing window to close. After that it issues three write strobes to the store and holds a busy flag for the full programming time. The bus slave uses this busy flag to leave its own address unacknowledged.

After reset the controller stays busy while it reads the store and hands the three bytes to the working registers, one per cycle. A blank store is one whose configuration byte reads as all ones. In that case the factory configuration is used. When the recalled configuration selects volatile mode, both wipers are loaded at the mute position of the selected taper.

Top module: `nvc_commit_ctrl`

## Requirements
- R1: After reset is released, and after two synchronizer cycles, `ld_en` pulses on three consecutive cycles with `ld_sel` = 2 (configuration), then 0 (wiper 0), then 1 (wiper 1). `busy` is high throughout and falls in the following cycle. Wiper bytes are loaded as `{2'b00, stored[5:0]}`.
- R2: If the stored configuration byte reads 8'hFF, the configuration is loaded as 8'h87. The wipers then follow the rule of R3 for that value.
- R3: If the recalled configuration has bit 2 set (volatile), both wipers load the mute code. The mute code is 6'd63 when configuration bit 0 is 0 and 6'd33 when bit 0 is 1.
- R4: A `stop_evt` sampled while idle, with `dirty` = 1 and `vol_mode` = 0 (and no zero-crossing wait), starts a commit in the next cycle. The commit strobes `mem_we` on three consecutive cycles at addresses 0, 1 and 2 with the wiper 0, wiper 1 and configuration bytes. `busy` stays high for exactly `T_WRITE` cycles.
- R5: A `stop_evt` while `vol_mode` = 1 leaves the store unwritten and `busy` low.
- R6: A `stop_evt` while `dirty` = 0 leaves the store unwritten and `busy` low.
- R7: If `zc_en` and `zc_pend` are both 1 when a commit is accepted, `busy` rises but no strobe is issued until `zc_pend` is seen low. The first strobe comes in the cycle after that. With `zc_en` = 0, `zc_pend` has no effect.
- R8: A `stop_evt` while `busy` is high is dropped. No second commit follows.
- R9: The bytes written are those present at the accepted `stop_evt`. Later changes on `w0_in`, `w1_in` and `cfg_in` do not reach the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_evt | input | 1 | One-cycle pulse: bus STOP ending a write |
| dirty | input | 1 | A setting changed in this transaction |
| vol_mode | input | 1 | Registers are volatile |
| zc_en | input | 1 | Zero-crossing detection enabled |
| zc_pend | input | 1 | A zero-crossing window is still open |
| w0_in | input | 8 | Working wiper 0 byte |
| w1_in | input | 8 | Working wiper 1 byte |
| cfg_in | input | 8 | Working configuration byte |
| busy | output | 1 | Recall or commit in progress; refuse addressing |
| mem_we | output | 1 | Store write strobe |
| mem_addr | output | 2 | Store address (0 wiper 0, 1 wiper 1, 2 config) |
| mem_wdata | output | 8 | Store write data |
| mem_rdata | input | 8 | Store read data, combinational on `mem_addr` |
| ld_en | output | 1 | Load strobe to working registers |
| ld_sel | output | 2 | Working register selected (same coding as `mem_addr`) |
| ld_data | output | 8 | Byte to load |

## Verification
The hardest states to reach from the ports are the zero-crossing wait and a STOP that lands in the middle of a running commit. Both states hide behind `busy` and produce no visible output of their own. The stimulus holds `zc_pend` high across several cycles after an accepted STOP and confirms that no strobe appears. It then drops `zc_pend` and checks that the first strobe comes exactly one cycle later. A second STOP with different data is fired two cycles into programming. The store contents and the total strobe count then show that the second STOP was dropped.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ZCWAIT = 2'd2,
    ST_PROG   = 2'd3
  } nvc_state_e;

  localparam int unsigned NUM_SLOTS = 3;
  localparam logic [1:0] SLOT_W0  = 2'd0;
  localparam logic [1:0] SLOT_W1  = 2'd1;
  localparam logic [1:0] SLOT_CFG = 2'd2;

  localparam logic [5:0] MUTE_FINE   = 6'd63;
  localparam logic [5:0] MUTE_COARSE = 6'd33;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;
endpackage

// File: rtl/nvc_seq.sv
module nvc_seq
  import nvc_pkg::*;
#(
  parameter int unsigned T_WRITE = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_evt,
  input  logic       dirty,
  input  logic       vol_mode,
  input  logic       zc_en,
  input  logic       zc_pend,
  output logic       take,
  output logic       busy,
  output logic       rec_act,
  output logic       wr_act,
  output logic [1:0] step
);
  localparam int unsigned CW = $clog2(T_WRITE + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(T_WRITE - 1);
  localparam logic [CW-1:0] LAST_RECALL = CW'(NUM_SLOTS - 1);
  localparam logic [CW-1:0] STROBES = CW'(NUM_SLOTS);

  nvc_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic start_ok;

  assign start_ok = stop_evt & dirty & ~vol_mode;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RECALL: begin
        if (cnt_q == LAST_RECALL) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (start_ok) begin
          cnt_d   = '0;
          state_d = (zc_en && zc_pend) ? ST_ZCWAIT : ST_PROG;
        end
      end
      ST_ZCWAIT: begin
        if (!zc_pend) state_d = ST_PROG;
      end
      ST_PROG: begin
        if (cnt_q == LAST_CNT) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RECALL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign take    = (state_q == ST_IDLE) && start_ok;
  assign busy    = (state_q != ST_IDLE);
  assign rec_act = (state_q == ST_RECALL);
  assign wr_act  = (state_q == ST_PROG) && (cnt_q < STROBES);
  assign step    = cnt_q[1:0];
endmodule

// File: rtl/nvc_snap.sv
module nvc_snap
  import nvc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] w0_in,
  input  logic [7:0] w1_in,
  input  logic [7:0] cfg_in,
  input  logic [1:0] slot,
  output logic [7:0] wdata
);
  logic [7:0] src [NUM_SLOTS];
  logic [7:0] hold_q [NUM_SLOTS];

  assign src[SLOT_W0]  = w0_in;
  assign src[SLOT_W1]  = w1_in;
  assign src[SLOT_CFG] = cfg_in;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[g] <= '0;
      end else if (take) begin
        hold_q[g] <= src[g];
      end
    end
  end

  always_comb begin
    case (slot)
      SLOT_W0:  wdata = hold_q[SLOT_W0];
      SLOT_W1:  wdata = hold_q[SLOT_W1];
      default:  wdata = hold_q[SLOT_CFG];
    endcase
  end
endmodule

// File: rtl/nvc_recall_fmt.sv
module nvc_recall_fmt
  import nvc_pkg::*;
#(
  parameter logic [7:0] CFG_DEFAULT = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_act,
  input  logic [1:0] step,
  input  logic [7:0] rdata,
  output logic [1:0] rd_addr,
  output logic [7:0] ld_data
);
  logic [7:0] cfg_now;
  logic [7:0] cfg_q;
  logic       cfg_en;
  logic [5:0] mute_code;
  logic [5:0] wiper_pos;

  assign rd_addr = (step == 2'd0) ? SLOT_CFG : (step - 2'd1);
  assign cfg_now = (rdata == BLANK_BYTE) ? CFG_DEFAULT : rdata;
  assign cfg_en  = rec_act && (step == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_now;
    end
  end

  assign mute_code = cfg_q[0] ? MUTE_COARSE : MUTE_FINE;
  assign wiper_pos = cfg_q[2] ? mute_code : rdata[5:0];
  assign ld_data   = (step == 2'd0) ? cfg_now : {2'b00, wiper_pos};
endmodule

// File: rtl/nvc_commit_ctrl.sv
module nvc_commit_ctrl
  import nvc_pkg::*;
#(
  parameter int unsigned T_WRITE     = 1_000_000,
  parameter logic [7:0]  CFG_DEFAULT = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_evt,
  input  logic       dirty,
  input  logic       vol_mode,
  input  logic       zc_en,
  input  logic       zc_pend,
  input  logic [7:0] w0_in,
  input  logic [7:0] w1_in,
  input  logic [7:0] cfg_in,
  output logic       busy,
  output logic       mem_we,
  output logic [1:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       ld_en,
  output logic [1:0] ld_sel,
  output logic [7:0] ld_data
);
  logic       sync1_q, srst_n;
  logic       take, rec_act, wr_act;
  logic [1:0] step, rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      srst_n  <= sync1_q;
    end
  end

  nvc_seq #(.T_WRITE(T_WRITE)) u_seq (
    .clk(clk), .rst_n(srst_n), .stop_evt(stop_evt), .dirty(dirty),
    .vol_mode(vol_mode), .zc_en(zc_en), .zc_pend(zc_pend),
    .take(take), .busy(busy), .rec_act(rec_act), .wr_act(wr_act), .step(step)
  );

  nvc_snap u_snap (
    .clk(clk), .rst_n(srst_n), .take(take), .w0_in(w0_in), .w1_in(w1_in),
    .cfg_in(cfg_in), .slot(step), .wdata(mem_wdata)
  );

  nvc_recall_fmt #(.CFG_DEFAULT(CFG_DEFAULT)) u_fmt (
    .clk(clk), .rst_n(srst_n), .rec_act(rec_act), .step(step),
    .rdata(mem_rdata), .rd_addr(rd_addr), .ld_data(ld_data)
  );

  assign mem_we   = wr_act;
  assign mem_addr = rec_act ? rd_addr : step;
  assign ld_en    = rec_act & srst_n;
  assign ld_sel   = rd_addr;
endmodule

// File: rtl/nvc_commit_ctrl_chk.sv
module nvc_commit_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_evt,
  input logic       dirty,
  input logic       vol_mode,
  input logic       busy,
  input logic       mem_we,
  input logic [1:0] mem_addr,
  input logic       ld_en,
  input logic [1:0] ld_sel
);
  a_r1_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> busy);
  a_r1_cfg_then_w0: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 2'd2) |=> (ld_en && ld_sel == 2'd0));
  a_r1_w0_then_w1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 2'd0) |=> (ld_en && ld_sel == 2'd1));
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_evt && dirty && !vol_mode) |=> busy);
  a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !ld_en));
  a_r4_addr_0_1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == 2'd0) |=> (mem_we && mem_addr == 2'd1));
  a_r4_addr_1_2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == 2'd1) |=> (mem_we && mem_addr == 2'd2));
  a_r5_volatile_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_evt && vol_mode) |=> !busy);
  a_r6_clean_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_evt && !dirty) |=> !busy);
endmodule

bind nvc_commit_ctrl nvc_commit_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .dirty(dirty),
  .vol_mode(vol_mode), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
  .ld_en(ld_en), .ld_sel(ld_sel)
);

// File: tb/nvc_commit_ctrl_bench.sv
`timescale 1ns/1ps
module nvc_commit_ctrl_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_evt = 1'b0, dirty = 1'b0, vol_mode = 1'b0, zc_en = 1'b0, zc_pend = 1'b0;
  logic [7:0] w0_in = 8'h00, w1_in = 8'h00, cfg_in = 8'h00;
  logic busy, mem_we, ld_en;
  logic [1:0] mem_addr, ld_sel;
  logic [7:0] mem_wdata, mem_rdata, ld_data;
  logic [7:0] mem [4];
  int nchk = 0, nfail = 0, we_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvc_commit_ctrl #(.T_WRITE(TW)) u_nvc_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .dirty(dirty),
    .vol_mode(vol_mode), .zc_en(zc_en), .zc_pend(zc_pend), .w0_in(w0_in),
    .w1_in(w1_in), .cfg_in(cfg_in), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // {vol_mode, dirty, w0, w1, cfg}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b1, 8'h05, 8'h0A, 8'h81},
    {1'b1, 1'b1, 8'h11, 8'h22, 8'h84},
    {1'b0, 1'b0, 8'h33, 8'h34, 8'h81},
    {1'b0, 1'b1, 8'h3F, 8'h00, 8'h80},
    {1'b0, 1'b1, 8'h21, 8'h12, 8'h83},
    {1'b1, 1'b0, 8'h01, 8'h02, 8'h85}
  };

  task automatic do_recall(input logic [7:0] m0, m1, m2,
                           input logic [7:0] ec, e0, e1, input string tag);
    rst_n = 1'b0;
    mem[0] = m0; mem[1] = m1; mem[2] = m2; mem[3] = 8'hFF;
    repeat (2) @(negedge clk);
    chk({tag, " busy in reset"}, busy, 1);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk({tag, " cfg load"}, {ld_en, ld_sel, ld_data}, {1'b1, 2'd2, ec});
    @(negedge clk);
    chk({tag, " w0 load"}, {ld_en, ld_sel, ld_data}, {1'b1, 2'd0, e0});
    chk({tag, " busy"}, busy, 1);
    @(negedge clk);
    chk({tag, " w1 load"}, {ld_en, ld_sel, ld_data}, {1'b1, 2'd1, e1});
    @(negedge clk);
    chk({tag, " released"}, {busy, ld_en}, 2'b00);
  endtask

  task automatic fire_stop(input logic [7:0] a, b, c);
    w0_in = a; w1_in = b; cfg_in = c;
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] exp_mem [3];
    int n, base;

    do_recall(8'h0A, 8'h15, 8'h81, 8'h81, 8'h0A, 8'h15, "R1 nonvolatile");
    do_recall(8'hC7, 8'h15, 8'h81, 8'h81, 8'h07, 8'h15, "R1 top bits");
    do_recall(8'h0A, 8'h15, 8'h84, 8'h84, 8'h3F, 8'h3F, "R3 fine mute");
    do_recall(8'h0A, 8'h15, 8'h85, 8'h85, 8'h21, 8'h21, "R3 coarse mute");
    do_recall(8'hFF, 8'hFF, 8'hFF, 8'h87, 8'h21, 8'h21, "R2 blank");
    do_recall(8'h0A, 8'h15, 8'h81, 8'h81, 8'h0A, 8'h15, "R1 restart");

    exp_mem[0] = 8'h0A; exp_mem[1] = 8'h15; exp_mem[2] = 8'h81;
    foreach (VEC[i]) begin
      logic expw;
      vol_mode = VEC[i][25];
      dirty    = VEC[i][24];
      expw = VEC[i][24] && !VEC[i][25];
      base = we_cnt;
      @(negedge clk);
      fire_stop(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      chk($sformatf("R4/R5/R6 vec%0d busy", i), busy, int'(expw));
      repeat (TW + 2) @(negedge clk);
      if (expw) begin
        exp_mem[0] = VEC[i][23:16]; exp_mem[1] = VEC[i][15:8]; exp_mem[2] = VEC[i][7:0];
      end
      chk($sformatf("R4/R5/R6 vec%0d store", i), {mem[0], mem[1], mem[2]},
          {exp_mem[0], exp_mem[1], exp_mem[2]});
      chk($sformatf("R4 vec%0d strobes", i), we_cnt - base, expw ? 3 : 0);
      chk($sformatf("R4 vec%0d idle", i), busy, 0);
    end
    vol_mode = 1'b0; dirty = 1'b1;

    // R4: strobe order, data, busy length
    fire_stop(8'h11, 8'h22, 8'h81);
    chk("R4 strobe0", {mem_we, mem_addr, mem_wdata}, {1'b1, 2'd0, 8'h11});
    @(negedge clk);
    chk("R4 strobe1", {mem_we, mem_addr, mem_wdata}, {1'b1, 2'd1, 8'h22});
    @(negedge clk);
    chk("R4 strobe2", {mem_we, mem_addr, mem_wdata}, {1'b1, 2'd2, 8'h81});
    @(negedge clk);
    chk("R4 strobes end", mem_we, 0);
    n = 3;
    while (busy) begin n++; @(negedge clk); end
    chk("R4 busy length", n, TW);

    // R7: zero-crossing wait
    zc_en = 1'b1; zc_pend = 1'b1;
    base = we_cnt;
    fire_stop(8'h30, 8'h31, 8'h83);
    repeat (6) @(negedge clk);
    chk("R7 held busy", busy, 1);
    chk("R7 no strobe", we_cnt - base, 0);
    zc_pend = 1'b0;
    @(negedge clk);
    chk("R7 first strobe", {mem_we, mem_addr}, {1'b1, 2'd0});
    wait_idle();
    chk("R7 store", {mem[0], mem[1], mem[2]}, {8'h30, 8'h31, 8'h83});

    // R7: pend ignored when detection off
    zc_en = 1'b0; zc_pend = 1'b1;
    fire_stop(8'h05, 8'h06, 8'h81);
    chk("R7 disabled immediate", {mem_we, mem_addr}, {1'b1, 2'd0});
    wait_idle();
    zc_pend = 1'b0;

    // R8: stop while busy dropped
    base = we_cnt;
    fire_stop(8'h12, 8'h13, 8'h81);
    @(negedge clk);
    fire_stop(8'h3A, 8'h3B, 8'h80);
    wait_idle();
    repeat (TW + 4) @(negedge clk);
    chk("R8 no second commit", busy, 0);
    chk("R8 strobe count", we_cnt - base, 3);
    chk("R8 store", {mem[0], mem[1], mem[2]}, {8'h12, 8'h13, 8'h81});

    // R9: snapshot at stop
    fire_stop(8'h2A, 8'h2B, 8'h81);
    w0_in = 8'h3C; w1_in = 8'h3D; cfg_in = 8'h80;
    wait_idle();
    chk("R9 snapshot", {mem[0], mem[1], mem[2]}, {8'h2A, 8'h2B, 8'h81});

    finish_run();
  end
endmodule